// File: doc/BRIEF.md
# Rolling-Shutter Row Readout Sequencer

This block produces the row timing for an image array read with an electronic rolling shutter, together with the framing of the pixel stream that leaves the array. Two row pointers move through the frame at the same pace. One marks the row whose pixels are being cleared. The other marks the row being read out. The clear pointer runs a programmed number of row periods ahead of the read pointer, and that lead is the exposure. For every row that is read, the block walks across the columns and presents one 12-bit pixel per clock. Each pixel is framed by line-valid and frame-valid, and carries a two-bit colour tag for the mosaic colour filter.

The readout window has a programmable origin and size, and either axis can be mirrored. Horizontal and vertical blanking fill out the line and frame periods. The colour tag is taken from the physical row and column parity, so it stays correct when the image is mirrored or panned. In place of converted samples, a synthetic source places the physical row and column numbers into each pixel word. Every setting is sampled only at a frame boundary, so the frame in progress always finishes with the geometry it started with.

Top module: `rs_readout_seq`

## Requirements
- R1: While `rst` is high, `lineValid`, `frameValid` and `rstValid` are low. At the first sample after `rst` falls, `frameValid` is high and `lineValid` is low.
- R2: Each line period lasts width + hb clock cycles, where hb is the blanking setting raised to 1 when it is 0. In each line period, `lineValid` is low for the first hb cycles and then high for width consecutive cycles.
- R3: `frameValid` stays high for exactly height line periods and then stays low for exactly vblank line periods. `lineValid` is never high while `frameValid` is low.
- R4: During `lineValid`, `pixData` equals physRow*64 + physCol, with each coordinate taken modulo 64 (bench widths). For window line k, physRow is rowStart+k, or rowStart+height-1-k when vertical mirroring is on. For window column i, physCol is colStart+i, or colStart+width-1-i when horizontal mirroring is on.
- R5: `bayerTag` equals {physRow[0], physCol[0]}. The codes are: 0 = green on a red row (even row, even column), 1 = red (even row, odd column), 2 = blue (odd row, even column), 3 = green on a blue row (odd row, odd column).
- R6: In a frame with stable settings, `rstValid` pulses exactly height times per frame period. Each pulse lasts one cycle and names a physical row on `rstRow`. The rise of `lineValid` for a row comes exactly E*(width+hb)+hb cycles after that row's `rstValid` pulse, where E is the exposure row count.
- R7: An exposure setting larger than the window height is treated as equal to the height.
- R8: A settings change made during a frame has no effect on that frame. Its timing, pixel order and data keep the old settings.
- R9: The frame after the change boundary starts at once with the new geometry, without an idle or stalled line period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the settings |
| cfgRowStart | input | ROW_W | First physical row of the window |
| cfgColStart | input | COL_W | First physical column of the window |
| cfgWidth | input | COL_W | Window width in pixels (at least 1) |
| cfgHeight | input | ROW_W | Window height in rows (at least 1) |
| cfgHBlank | input | HB_W | Horizontal blanking cycles per line (0 treated as 1) |
| cfgVBlank | input | VB_W | Vertical blanking line periods per frame |
| cfgExpRows | input | ROW_W | Exposure as the clear-to-read lead in row periods |
| cfgMirrorH | input | 1 | Reverse column order |
| cfgMirrorV | input | 1 | Reverse row order |
| pixData | output | PIX_W | Synthetic pixel: row and column fields |
| bayerTag | output | 2 | Colour tag of the current pixel |
| lineValid | output | 1 | High for each valid pixel of a line |
| frameValid | output | 1 | High over the active rows of a frame |
| rstValid | output | 1 | One-cycle pulse: clear the row on rstRow |
| rstRow | output | ROW_W | Physical row being cleared |

## Verification
The bench builds the block with 6-bit row and column fields, 4-bit blanking fields and a 12-bit pixel. At these widths each pixel word holds its full physical coordinates, and several frames fit in a few hundred cycles. This allows every pixel of every frame to be checked against an independently computed window walk. It also covers odd window origins with both mirror axes, an exposure above the height, a zero horizontal blanking setting, zero exposure, and settings changed mid-frame across consecutive frames.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;

  typedef enum logic [1:0] {
    TAG_GREEN_R = 2'd0,
    TAG_RED     = 2'd1,
    TAG_BLUE    = 2'd2,
    TAG_GREEN_B = 2'd3
  } bayerTag_t;

  typedef struct packed {
    logic lineAct;
    logic frameAct;
    logic rstPulse;
  } seqStrobe_t;

endpackage

// File: rtl/rs_seq_ctrl.sv
module rs_seq_ctrl
  import rs_seq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  parameter int HB_W  = 12,
  parameter int VB_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] cfgRowStart,
  input  logic [COL_W-1:0] cfgColStart,
  input  logic [COL_W-1:0] cfgWidth,
  input  logic [ROW_W-1:0] cfgHeight,
  input  logic [HB_W-1:0]  cfgHBlank,
  input  logic [VB_W-1:0]  cfgVBlank,
  input  logic [ROW_W-1:0] cfgExpRows,
  input  logic             cfgMirrorH,
  input  logic             cfgMirrorV,
  output seqStrobe_t       strb,
  output logic [ROW_W-1:0] winRow,
  output logic [COL_W-1:0] winCol,
  output logic [ROW_W-1:0] rstIdx,
  output logic [ROW_W-1:0] actRowStart,
  output logic [COL_W-1:0] actColStart,
  output logic [COL_W-1:0] actWidth,
  output logic [ROW_W-1:0] actHeight,
  output logic             actMirH,
  output logic             actMirV
);

  localparam int LCW = ((COL_W > HB_W) ? COL_W : HB_W) + 1;
  localparam int FCW = ((ROW_W > VB_W) ? ROW_W : VB_W) + 1;
  localparam int SW  = FCW + 1;

  logic [HB_W-1:0]  actHB, nxtHB;
  logic [VB_W-1:0]  actVB;
  logic [ROW_W-1:0] actExp, nxtExp;
  logic [LCW-1:0]   colCnt, linePeriod;
  logic [FCW-1:0]   lineCnt, framePeriod;
  logic [SW-1:0]    rstSum, rstWrap;
  logic             lineEnd, frameEnd, rowAct;

  // settings as they will be held for the next frame
  always_comb begin
    nxtHB  = (cfgHBlank == '0) ? HB_W'(1) : cfgHBlank;
    nxtExp = (cfgExpRows > cfgHeight) ? cfgHeight : cfgExpRows;
  end

  assign linePeriod  = LCW'(actWidth) + LCW'(actHB);
  assign framePeriod = FCW'(actHeight) + FCW'(actVB);
  assign lineEnd     = (colCnt == linePeriod - LCW'(1));
  assign frameEnd    = lineEnd && (lineCnt == framePeriod - FCW'(1));

  always_ff @(posedge clk) begin
    if (rst || frameEnd) begin
      actRowStart <= cfgRowStart;
      actColStart <= cfgColStart;
      actWidth    <= cfgWidth;
      actHeight   <= cfgHeight;
      actHB       <= nxtHB;
      actVB       <= cfgVBlank;
      actExp      <= nxtExp;
      actMirH     <= cfgMirrorH;
      actMirV     <= cfgMirrorV;
    end
    if (rst) begin
      colCnt  <= '0;
      lineCnt <= '0;
    end else if (lineEnd) begin
      colCnt  <= '0;
      lineCnt <= frameEnd ? '0 : lineCnt + FCW'(1);
    end else begin
      colCnt  <= colCnt + LCW'(1);
    end
  end

  // clear pointer: read line plus exposure lead, folded into the next frame
  always_comb begin
    rstSum  = SW'(lineCnt) + SW'(actExp);
    rstWrap = (rstSum >= SW'(framePeriod)) ? rstSum - SW'(framePeriod) : rstSum;
  end

  assign rowAct        = (lineCnt < FCW'(actHeight));
  assign strb.frameAct = rowAct;
  assign strb.lineAct  = rowAct && (colCnt >= LCW'(actHB));
  assign strb.rstPulse = (colCnt == '0) && (rstWrap < SW'(actHeight));
  assign winRow        = ROW_W'(lineCnt);
  assign winCol        = COL_W'(colCnt - LCW'(actHB));
  assign rstIdx        = ROW_W'(rstWrap);

endmodule

// File: rtl/rs_seq_dpath.sv
module rs_seq_dpath
  import rs_seq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strb,
  input  logic [ROW_W-1:0] winRow,
  input  logic [COL_W-1:0] winCol,
  input  logic [ROW_W-1:0] rstIdx,
  input  logic [ROW_W-1:0] actRowStart,
  input  logic [COL_W-1:0] actColStart,
  input  logic [COL_W-1:0] actWidth,
  input  logic [ROW_W-1:0] actHeight,
  input  logic             actMirH,
  input  logic             actMirV,
  output logic [PIX_W-1:0] pixData,
  output bayerTag_t        bayerTag,
  output logic             lineValid,
  output logic             frameValid,
  output logic             rstValid,
  output logic [ROW_W-1:0] rstRow
);

  localparam int HALF = PIX_W / 2;

  logic [ROW_W-1:0] physRow, physRst;
  logic [COL_W-1:0] physCol;

  // window index to physical array coordinate
  always_comb begin
    physRow = actMirV ? actRowStart + (actHeight - ROW_W'(1) - winRow)
                      : actRowStart + winRow;
    physRst = actMirV ? actRowStart + (actHeight - ROW_W'(1) - rstIdx)
                      : actRowStart + rstIdx;
    physCol = actMirH ? actColStart + (actWidth - COL_W'(1) - winCol)
                      : actColStart + winCol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pixData    <= '0;
      bayerTag   <= TAG_GREEN_R;
      lineValid  <= 1'b0;
      frameValid <= 1'b0;
      rstValid   <= 1'b0;
      rstRow     <= '0;
    end else begin
      lineValid  <= strb.lineAct;
      frameValid <= strb.frameAct;
      rstValid   <= strb.rstPulse;
      rstRow     <= physRst;
      pixData    <= strb.lineAct ? PIX_W'({HALF'(physRow), HALF'(physCol)}) : '0;
      bayerTag   <= bayerTag_t'({physRow[0], physCol[0]});
    end
  end

endmodule

// File: rtl/rs_readout_seq.sv
module rs_readout_seq
  import rs_seq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  parameter int HB_W  = 12,
  parameter int VB_W  = 12,
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] cfgRowStart,
  input  logic [COL_W-1:0] cfgColStart,
  input  logic [COL_W-1:0] cfgWidth,
  input  logic [ROW_W-1:0] cfgHeight,
  input  logic [HB_W-1:0]  cfgHBlank,
  input  logic [VB_W-1:0]  cfgVBlank,
  input  logic [ROW_W-1:0] cfgExpRows,
  input  logic             cfgMirrorH,
  input  logic             cfgMirrorV,
  output logic [PIX_W-1:0] pixData,
  output logic [1:0]       bayerTag,
  output logic             lineValid,
  output logic             frameValid,
  output logic             rstValid,
  output logic [ROW_W-1:0] rstRow
);

  seqStrobe_t       strb;
  bayerTag_t        tagInt;
  logic [ROW_W-1:0] winRow, rstIdx, actRowStart, actHeight;
  logic [COL_W-1:0] winCol, actColStart, actWidth;
  logic             actMirH, actMirV;

  rs_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .HB_W(HB_W), .VB_W(VB_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cfgRowStart(cfgRowStart), .cfgColStart(cfgColStart),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgHBlank(cfgHBlank), .cfgVBlank(cfgVBlank), .cfgExpRows(cfgExpRows),
    .cfgMirrorH(cfgMirrorH), .cfgMirrorV(cfgMirrorV),
    .strb(strb), .winRow(winRow), .winCol(winCol), .rstIdx(rstIdx),
    .actRowStart(actRowStart), .actColStart(actColStart),
    .actWidth(actWidth), .actHeight(actHeight),
    .actMirH(actMirH), .actMirV(actMirV)
  );

  rs_seq_dpath #(.ROW_W(ROW_W), .COL_W(COL_W), .PIX_W(PIX_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .winRow(winRow), .winCol(winCol), .rstIdx(rstIdx),
    .actRowStart(actRowStart), .actColStart(actColStart),
    .actWidth(actWidth), .actHeight(actHeight),
    .actMirH(actMirH), .actMirV(actMirV),
    .pixData(pixData), .bayerTag(tagInt),
    .lineValid(lineValid), .frameValid(frameValid),
    .rstValid(rstValid), .rstRow(rstRow)
  );

  assign bayerTag = tagInt;

endmodule

// File: rtl/rs_readout_seq_chk.sv
module rs_readout_seq_chk #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             lineValid,
  input logic             frameValid,
  input logic             rstValid,
  input logic [PIX_W-1:0] pixData,
  input logic [1:0]       bayerTag
);

  localparam int HALF = PIX_W / 2;

  // R3: pixels only inside the frame
  a_r3_line_in_frame: assert property (@(posedge clk) disable iff (rst)
    lineValid |-> frameValid);

  // R3: a frame opens with blanking before its first pixel
  a_r3_frame_opens_blank: assert property (@(posedge clk) disable iff (rst)
    $rose(frameValid) |-> !lineValid);

  // R6: the clear strobe lasts a single cycle
  a_r6_rst_single: assert property (@(posedge clk) disable iff (rst)
    rstValid |=> !rstValid);

  // R4: the row field holds steady along a line
  a_r4_row_steady: assert property (@(posedge clk) disable iff (rst)
    (lineValid && $past(lineValid)) |-> (pixData[PIX_W-1:HALF] == $past(pixData[PIX_W-1:HALF])));

  // R4: the column field moves by one per pixel, either direction
  a_r4_col_step: assert property (@(posedge clk) disable iff (rst)
    (lineValid && $past(lineValid)) |->
      ((pixData[HALF-1:0] == $past(pixData[HALF-1:0]) + HALF'(1)) ||
       (pixData[HALF-1:0] == $past(pixData[HALF-1:0]) - HALF'(1))));

  // R5: along a line the row colour holds and the column colour alternates
  a_r5_tag_alternates: assert property (@(posedge clk) disable iff (rst)
    (lineValid && $past(lineValid)) |->
      ((bayerTag[1] == $past(bayerTag[1])) && (bayerTag[0] != $past(bayerTag[0]))));

endmodule

bind rs_readout_seq rs_readout_seq_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .lineValid(lineValid), .frameValid(frameValid),
  .rstValid(rstValid), .pixData(pixData), .bayerTag(bayerTag)
);

// File: tb/rs_readout_seq_tb.sv
module rs_readout_seq_tb;

  localparam int ROW_W = 6;
  localparam int COL_W = 6;
  localparam int HB_W  = 4;
  localparam int VB_W  = 4;
  localparam int PIX_W = 12;

  typedef struct {
    int rs, cs, w, h, hb, vb, e;
    bit mh, mv;
  } cfg_s;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ROW_W-1:0] cfgRowStart = '0, cfgHeight = '0, cfgExpRows = '0;
  logic [COL_W-1:0] cfgColStart = '0, cfgWidth = '0;
  logic [HB_W-1:0]  cfgHBlank = '0;
  logic [VB_W-1:0]  cfgVBlank = '0;
  logic cfgMirrorH = 1'b0, cfgMirrorV = 1'b0;
  logic [PIX_W-1:0] pixData;
  logic [1:0] bayerTag;
  logic lineValid, frameValid, rstValid;
  logic [ROW_W-1:0] rstRow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;
  int rstAt [64];

  always #5 clk = ~clk;

  rs_readout_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .HB_W(HB_W), .VB_W(VB_W), .PIX_W(PIX_W)) u_dut (
    .clk(clk), .rst(rst),
    .cfgRowStart(cfgRowStart), .cfgColStart(cfgColStart),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgHBlank(cfgHBlank), .cfgVBlank(cfgVBlank), .cfgExpRows(cfgExpRows),
    .cfgMirrorH(cfgMirrorH), .cfgMirrorV(cfgMirrorV),
    .pixData(pixData), .bayerTag(bayerTag),
    .lineValid(lineValid), .frameValid(frameValid),
    .rstValid(rstValid), .rstRow(rstRow)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && rstValid) rstAt[rstRow] = cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic applyCfg(input cfg_s c);
    cfgRowStart = ROW_W'(c.rs);
    cfgColStart = COL_W'(c.cs);
    cfgWidth    = COL_W'(c.w);
    cfgHeight   = ROW_W'(c.h);
    cfgHBlank   = HB_W'(c.hb);
    cfgVBlank   = VB_W'(c.vb);
    cfgExpRows  = ROW_W'(c.e);
    cfgMirrorH  = c.mh;
    cfgMirrorV  = c.mv;
  endtask

  // Entered at the sample where frameValid has just risen; returns at the next rise.
  task automatic checkFrame(input cfg_s c, input bit chkExp, input string tag);
    int hb = (c.hb == 0) ? 1 : c.hb;
    int e  = (c.e > c.h) ? c.h : c.e;
    int p  = c.w + hb;
    int lvBad = 0, fvBad = 0, dataBad = 0, tagBad = 0, expBad = 0, rstCnt = 0, low = 0;
    int gotD = 0, expD = 0;
    for (int k = 0; k < c.h * p; k++) begin
      int ln  = k / p;
      int pos = k % p;
      bit lvExp = (pos >= hb);
      int pr = (c.mv ? c.rs + c.h - 1 - ln : c.rs + ln) % 64;
      if (rstValid) rstCnt++;
      if (!frameValid) fvBad++;
      if (lineValid !== lvExp) lvBad++;
      if (lvExp) begin
        int i  = pos - hb;
        int pc = (c.mh ? c.cs + c.w - 1 - i : c.cs + i) % 64;
        int ed = pr * 64 + pc;
        if (int'(pixData) != ed) begin
          if (dataBad == 0) begin gotD = int'(pixData); expD = ed; end
          dataBad++;
        end
        if (int'(bayerTag) != ((pr % 2) * 2 + (pc % 2))) tagBad++;
        if (chkExp && pos == hb && (cyc - rstAt[pr]) != e * p + hb) expBad++;
      end
      @(negedge clk);
    end
    while (!frameValid && low < 4096) begin
      if (lineValid) lvBad++;
      if (rstValid) rstCnt++;
      low++;
      @(negedge clk);
    end
    chk(lvBad == 0, "R2", lvBad, 0, {tag, " lineValid pattern mismatches"});
    chk(fvBad == 0, "R3", fvBad, 0, {tag, " frameValid dropped inside frame"});
    chk(low == c.vb * p, "R3", low, c.vb * p, {tag, " frameValid low cycles"});
    chk(dataBad == 0, "R4", gotD, expD, {tag, " first bad pixel word"});
    chk(tagBad == 0, "R5", tagBad, 0, {tag, " colour tag mismatches"});
    if (chkExp) begin
      chk(expBad == 0, "R6", expBad, 0, {tag, " clear-to-read spacing mismatches"});
      chk(rstCnt == c.h, "R6", rstCnt, c.h, {tag, " clear pulses per frame"});
    end
  endtask

  cfg_s cfgA = '{rs: 1, cs: 2, w: 6, h: 4, hb: 3, vb: 2, e: 2, mh: 0, mv: 0};
  cfg_s cfgB = '{rs: 3, cs: 5, w: 5, h: 3, hb: 1, vb: 1, e: 9, mh: 1, mv: 1};
  cfg_s cfgC = '{rs: 5, cs: 0, w: 7, h: 5, hb: 0, vb: 2, e: 0, mh: 1, mv: 0};

  task automatic testReset();
    applyCfg(cfgA);
    rst = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!lineValid && !frameValid && !rstValid, "R1",
          {29'd0, lineValid, frameValid, rstValid}, 0, "outputs during reset");
    end
    rst = 1'b0;
    @(negedge clk);
    chk(frameValid && !lineValid, "R1", {30'd0, frameValid, lineValid}, 2, "first sample after reset");
  endtask

  task automatic testPlain();
    checkFrame(cfgA, 1'b0, "plain first");
    checkFrame(cfgA, 1'b1, "plain steady");
    checkFrame(cfgA, 1'b1, "plain steady 2");
  endtask

  task automatic testMirrorClamp();
    applyCfg(cfgB);
    checkFrame(cfgA, 1'b1, "R8 old frame kept");
    checkFrame(cfgB, 1'b0, "R9 first new frame");
    checkFrame(cfgB, 1'b1, "R7 mirror clamp");
  endtask

  task automatic testZeroExp();
    applyCfg(cfgC);
    checkFrame(cfgB, 1'b1, "R8 old frame kept");
    checkFrame(cfgC, 1'b0, "R9 first new frame");
    checkFrame(cfgC, 1'b1, "R2 R6 zero blank zero exposure");
  endtask

  initial begin
    testReset();
    testPlain();
    testMirrorClamp();
    testZeroExp();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", 0, 1, "run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule